// File: doc/BRIEF.md
# Endian-Aware Bus Width Adapter

This block sits between a 32-bit internal access port and an external device bus that may be 8, 16 or 32 bits wide. The internal side issues one byte, word or longword read or write at a time. The adapter splits the access into as many external beats as the device width needs. It places each byte on the lane where the device expects it and, for reads, gathers the returned bytes into one right-justified value. Software takes no part in any of this.

Byte order is chosen once. While reset is held, the adapter samples `mode_pin`, and the result stays fixed until the next reset. Before each access the adapter checks it. If the device width is not allowed for the selected memory kind, or if the access is misaligned or uses the reserved size code, the adapter answers with an error and runs no external beat.

The internal port uses valid/ready. The requester raises `req_valid` and holds `req_write`, `req_size`, `req_addr` and `req_wdata` stable until it sees `req_ready`. The adapter raises `req_ready` for one cycle, only when the access is finished. That is the cycle in which the last external beat completes, or the cycle in which an error is reported. `req_rdata` and `req_err` are valid in that cycle.

On the device side, `ext_valid` stays high, with address, lanes and write data steady, until the device returns `ext_ready`. A slow device therefore stalls the adapter as long as it needs. The requester can only wait. `mem_kind` and `dev_width` are static and may only change while no access is in progress.

Top module: `bus_width_adapter`

## Requirements
- R1: While `rst_n` is low, `mode_pin` is sampled: 0 selects big-endian order, 1 selects little-endian order. Any change of `mode_pin` after reset has no effect on byte placement.
- R2: In big-endian order, the byte at the lowest address holds the most significant byte of the value. Within a beat on a device of N bytes, byte address offset k (relative to the N-aligned beat address) travels on lane N-1-k. Lane j is bits 8j+7:8j, and the device uses lanes 0 to N-1.
- R3: In little-endian order, the byte at the lowest address holds the least significant byte of the value, and offset k travels on lane k.
- R4: Access size is coded `req_size` 0/1/2 = 1/2/4 bytes (S), and device width `dev_width` 0/1/2 = 1/2/4 bytes (N). An access takes S/N beats when S > N, and one beat otherwise. Beat b drives `ext_addr` = `req_addr` + b·min(S,N).
- R5: Read data is right-justified in `req_rdata`, with unused upper bytes zero. Device lanes at or above N are ignored.
- R6: Without an error, `req_ready` is high only in the cycle in which `ext_ready` completes the last beat. It stays low out of reset and while idle.
- R7: Allowed widths depend on `mem_kind`: 0 (plain memory) allows 8, 16 and 32 bits; 1 (synchronous DRAM) allows 16 and 32; 2 (card interface) allows 8 and 16; 3 allows none. Any other combination gives `req_err` together with `req_ready` and no external beat.
- R8: A word access at an odd address, a longword access at an address that is not a multiple of 4, or `req_size` = 3 gives `req_err` and no external beat.
- R9: `ext_be` marks exactly the lanes that carry bytes of the current beat: min(S,N) lanes, all below N. A write changes no other memory byte.
- R10: Once raised, `ext_valid` stays high with `ext_addr` and `ext_be` unchanged until `ext_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset (synchronous) |
| mode_pin | input | 1 | Byte-order strap, sampled during reset |
| mem_kind | input | 2 | Memory kind: 0 plain, 1 synchronous DRAM, 2 card, 3 none |
| dev_width | input | 2 | Device width: 0 = 8, 1 = 16, 2 = 32 bits |
| req_valid | input | 1 | Internal access request |
| req_ready | output | 1 | Access finished (one cycle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write value, right-justified |
| req_rdata | output | 32 | Read value, right-justified |
| req_err | output | 1 | Access rejected (with req_ready) |
| ext_valid | output | 1 | External beat active |
| ext_ready | input | 1 | Device completes the beat |
| ext_write | output | 1 | Beat direction |
| ext_addr | output | ADDR_W | Beat byte address |
| ext_be | output | 4 | Active lanes |
| ext_wdata | output | 32 | Lane write data |
| ext_rdata | input | 32 | Lane read data |

## Verification
The bench runs every access size against every device width in both byte orders, using a memory model that places bytes on lanes as the requirements describe. It compares the whole memory after each write, so a lane swapped within a beat or a stray lane enable shows up as a wrong or extra byte. It counts beats per access and checks each beat address. A design that finished early would report fewer beats and return partial read data. A design that stepped the address by the access size, and not by the device width, would fail the per-beat address check.

The device inserts varying wait cycles and drives junk on its unused lanes. A design that let its address drift during a stall, or that picked up the upper lanes, would be caught. After every reset the bench flips the strap pin, so a design that kept following the pin would corrupt the byte order. Illegal width combinations, misaligned addresses and the reserved size code must all come back as errors with no external beat at all.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = LANES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    DW_8    = 2'd0,
    DW_16   = 2'd1,
    DW_32   = 2'd2,
    DW_RSVD = 2'd3
  } dev_width_e;

  typedef enum logic [1:0] {
    MK_PLAIN = 2'd0,
    MK_SDRAM = 2'd1,
    MK_CARD  = 2'd2,
    MK_NONE  = 2'd3
  } mem_kind_e;

  // log2 of the bytes moved per beat
  function automatic logic [1:0] beat_lg(input logic [1:0] size_lg,
                                         input logic [1:0] width_lg);
    return (size_lg < width_lg) ? size_lg : width_lg;
  endfunction

  // mask = 2^lg - 1, kept to two bits
  function automatic logic [1:0] lg_mask(input logic [1:0] lg);
    logic [2:0] full;
    full = (3'd1 << lg) - 3'd1;
    return full[1:0];
  endfunction
endpackage

// File: rtl/bwa_legal.sv
module bwa_legal
  import bwa_pkg::*;
(
  input  logic [1:0] mem_kind,
  input  logic [1:0] dev_width,
  input  logic [1:0] size,
  input  logic [1:0] addr_lo,
  output logic       width_bad,
  output logic       align_bad,
  output logic       any_bad
);
  mem_kind_e  kind;
  dev_width_e wid;
  acc_size_e  sz;

  assign kind = mem_kind_e'(mem_kind);
  assign wid  = dev_width_e'(dev_width);
  assign sz   = acc_size_e'(size);

  always_comb begin
    unique case (kind)
      MK_PLAIN: width_bad = (wid == DW_RSVD);
      MK_SDRAM: width_bad = !(wid == DW_16 || wid == DW_32);
      MK_CARD:  width_bad = !(wid == DW_8  || wid == DW_16);
      default:  width_bad = 1'b1;
    endcase
  end

  always_comb begin
    unique case (sz)
      SZ_BYTE: align_bad = 1'b0;
      SZ_WORD: align_bad = addr_lo[0];
      SZ_LONG: align_bad = (addr_lo != 2'b00);
      default: align_bad = 1'b1;
    endcase
  end

  assign any_bad = width_bad | align_bad;
endmodule

// File: rtl/bwa_ctrl.sv
module bwa_ctrl
  import bwa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_pin,
  input  logic       req_valid,
  input  logic       req_bad,
  input  logic [1:0] size,
  input  logic [1:0] width,
  input  logic       ext_ready,
  output logic       big_endian,
  output logic       busy,
  output logic [1:0] beat,
  output logic       start,
  output logic       beat_done,
  output logic       req_ready,
  output logic       req_err
);
  typedef enum logic {ST_IDLE, ST_BUSY} st_e;

  st_e        st_q;
  logic [1:0] beat_q;
  logic       big_q;
  logic [1:0] span_lg;
  logic [1:0] last_idx;
  logic       last_beat;

  assign span_lg   = (size > width) ? (size - width) : 2'd0;
  assign last_idx  = lg_mask(span_lg);
  assign last_beat = (beat_q == last_idx);

  assign busy      = (st_q == ST_BUSY);
  assign start     = (st_q == ST_IDLE) && req_valid && !req_bad;
  assign req_err   = (st_q == ST_IDLE) && req_valid && req_bad;
  assign beat_done = busy && ext_ready;
  assign req_ready = req_err || (beat_done && last_beat);
  assign beat      = beat_q;
  assign big_endian = big_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= 2'd0;
      big_q  <= !mode_pin;
    end else begin
      if (start) begin
        st_q   <= ST_BUSY;
        beat_q <= 2'd0;
      end else if (beat_done) begin
        if (last_beat) begin
          st_q   <= ST_IDLE;
          beat_q <= 2'd0;
        end else begin
          beat_q <= beat_q + 2'd1;
        end
      end
    end
  end

  // R1
  endian_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(big_q));

  // R4
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (beat_q <= last_idx));
endmodule

// File: rtl/bwa_lanes.sv
module bwa_lanes
  import bwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              big_endian,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic [1:0]        width,
  input  logic [1:0]        addr_lo,
  input  logic [1:0]        beat,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [DATA_W-1:0] ext_wdata,
  output logic [LANES-1:0]  ext_be,
  output logic [DATA_W-1:0] cap_data
);
  logic [1:0] lgb;
  logic [1:0] nmask;
  logic [1:0] smask;
  logic [1:0] lane_of [LANES];
  logic [1:0] sig_of  [LANES];
  logic       act     [LANES];
  logic [LANES-1:0] dev_lanes;

  assign lgb   = beat_lg(size, width);
  assign nmask = lg_mask(width);
  assign smask = lg_mask(size);

  // one slot per byte of the internal value, in address order
  for (genvar g = 0; g < LANES; g++) begin : g_slot
    logic [1:0] idx;
    logic [1:0] off;
    assign idx        = 2'(g);
    assign off        = (addr_lo + idx) & nmask;
    assign lane_of[g] = big_endian ? (nmask - off) : off;
    assign sig_of[g]  = big_endian ? (smask - idx) : idx;
    assign act[g]     = active && (idx <= smask) && ((idx >> lgb) == beat);
  end

  always_comb begin
    ext_wdata = '0;
    ext_be    = '0;
    cap_data  = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int g = 0; g < LANES; g++) begin
        if (act[g] && (int'(lane_of[g]) == l)) begin
          ext_be[l] = 1'b1;
          ext_wdata[l*8 +: 8] = wdata[sig_of[g]*8 +: 8];
          if (!write) cap_data[sig_of[g]*8 +: 8] = ext_rdata[l*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) dev_lanes[l] = (l <= int'(nmask));
  end

  // R9
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones(ext_be) == (1 << lgb)));

  // R9
  lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((ext_be & ~dev_lanes) == '0));
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  input  logic [1:0]        mem_kind,
  input  logic [1:0]        dev_width,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       req_rdata,
  output logic              req_err,
  output logic              ext_valid,
  input  logic              ext_ready,
  output logic              ext_write,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [3:0]        ext_be,
  output logic [31:0]       ext_wdata,
  input  logic [31:0]       ext_rdata
);
  logic              width_bad, align_bad, any_bad;
  logic              big_endian, busy, start, beat_done;
  logic [1:0]        beat;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] acc_q;
  logic [ADDR_W-1:0] step;

  bwa_legal u_legal (
    .mem_kind  (mem_kind),
    .dev_width (dev_width),
    .size      (req_size),
    .addr_lo   (req_addr[1:0]),
    .width_bad (width_bad),
    .align_bad (align_bad),
    .any_bad   (any_bad)
  );

  bwa_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_pin   (mode_pin),
    .req_valid  (req_valid),
    .req_bad    (any_bad),
    .size       (req_size),
    .width      (dev_width),
    .ext_ready  (ext_ready),
    .big_endian (big_endian),
    .busy       (busy),
    .beat       (beat),
    .start      (start),
    .beat_done  (beat_done),
    .req_ready  (req_ready),
    .req_err    (req_err)
  );

  bwa_lanes u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (busy),
    .big_endian (big_endian),
    .write      (req_write),
    .size       (req_size),
    .width      (dev_width),
    .addr_lo    (req_addr[1:0]),
    .beat       (beat),
    .wdata      (req_wdata),
    .ext_rdata  (ext_rdata),
    .ext_wdata  (ext_wdata),
    .ext_be     (ext_be),
    .cap_data   (cap_data)
  );

  assign step      = ADDR_W'(beat) << beat_lg(req_size, dev_width);
  assign ext_addr  = req_addr + step;
  assign ext_valid = busy;
  assign ext_write = req_write;

  always_ff @(posedge clk) begin
    if (!rst_n)         acc_q <= '0;
    else if (start)     acc_q <= '0;
    else if (beat_done) acc_q <= acc_q | cap_data;
  end

  assign req_rdata = acc_q | (beat_done ? cap_data : '0);

  // R6
  done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_err) |-> (ext_valid && ext_ready));

  // R7
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (req_ready && !ext_valid));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (width_bad || align_bad));

  // R10
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_addr) && $stable(ext_be)));
endmodule

// File: tb/bus_width_adapter_tb.sv
module bus_width_adapter_tb;
  typedef struct {
    bit          is_err;
    bit          is_read;
    bit          is_write;
    int          beats;
    logic [31:0] rdata;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_pin = 0;
  logic [1:0]  mem_kind = 0, dev_width = 0;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic        req_ready, req_err, ext_valid, ext_write;
  logic [31:0] req_rdata, ext_addr, ext_wdata;
  logic [3:0]  ext_be;
  logic        ext_ready = 0;
  logic [31:0] ext_rdata = 0;

  logic [7:0] mem     [64];
  logic [7:0] exp_mem [64];
  bit   big_b = 1;
  exp_t exp_q[$];
  int   cur_addr = 0, cur_step = 1, cur_base = 0;
  int   dev_total = 0, dev_bad = 0, wait_cnt = 0, wait_pat = 0;
  bit   waiting = 0;
  logic [31:0] hold_addr = 0;
  int   mon_hs = 0, mon_idx = 0, mon_base = 0, mon_bad_base = 0;
  int   mon_checks = 0, mon_errors = 0, main_checks = 0, main_errors = 0;

  always #5 clk = ~clk;

  bus_width_adapter u_dut (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .mem_kind(mem_kind),
    .dev_width(dev_width), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_rdata(req_rdata), .req_err(req_err),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_write(ext_write),
    .ext_addr(ext_addr), .ext_be(ext_be), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata)
  );

  // device model: lane placement taken from R2/R3, junk on unused lanes
  always @(negedge clk) begin
    if (ext_ready) begin
      ext_ready = 0;
      wait_cnt  = wait_pat;
      wait_pat  = (wait_pat == 2) ? 0 : wait_pat + 1;
      waiting   = 0;
    end else if (rst_n && ext_valid) begin
      if (!waiting) begin
        hold_addr = ext_addr;
        waiting   = 1;
      end else if (ext_addr != hold_addr) dev_bad++;
      if (wait_cnt > 0) wait_cnt--;
      else begin
        int n, base;
        n = 1 << dev_width;
        if (ext_addr != 32'(cur_addr + (dev_total - cur_base) * cur_step)) dev_bad++;
        base = int'(ext_addr) & ~(n - 1);
        ext_rdata = 32'hEEEE_EEEE;
        for (int l = 0; l < n; l++) begin
          int off;
          off = big_b ? (n - 1 - l) : l;
          ext_rdata[l*8 +: 8] = mem[(base + off) & 63];
          if (ext_write && ext_be[l]) mem[(base + off) & 63] = ext_wdata[l*8 +: 8];
        end
        dev_total++;
        ext_ready = 1;
      end
    end
  end

  task automatic mchk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
    mon_checks++;
    if (!ok) begin
      mon_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // monitor / scoreboard
  always begin
    @(negedge clk);
    #2;
    if (rst_n && req_valid && req_ready) begin
      exp_t e;
      int beats, bad;
      e = exp_q[mon_idx];
      mon_idx++;
      beats = dev_total - mon_base;
      mon_base = dev_total;
      bad = dev_bad - mon_bad_base;
      mon_bad_base = dev_bad;
      mchk(req_err == e.is_err, "R7 R8", "error flag", 32'(req_err), 32'(e.is_err));
      mchk(beats == e.beats, "R4 R6", "beat count", 32'(beats), 32'(e.beats));
      mchk(bad == 0, "R4 R10", "beat address", 32'(bad), 32'd0);
      if (e.is_read && !e.is_err)
        mchk(req_rdata == e.rdata, "R5", "read data", req_rdata, e.rdata);
      if (e.is_write && !e.is_err) begin
        int diff;
        diff = 0;
        for (int j = 0; j < 64; j++) if (mem[j] !== exp_mem[j]) diff++;
        mchk(diff == 0, big_b ? "R1 R2 R9" : "R1 R3 R9", "bytes differing", 32'(diff), 32'd0);
      end
      mon_hs++;
    end
  end

  function automatic logic [31:0] model_read(input int a, input int sz);
    logic [31:0] v;
    int s;
    v = 0;
    s = 1 << sz;
    for (int i = 0; i < s; i++) v[(big_b ? (s - 1 - i) : i)*8 +: 8] = exp_mem[(a + i) & 63];
    return v;
  endfunction

  task automatic access(input bit wr, input int sz, input int a,
                        input logic [31:0] wd, input bit bad);
    exp_t e;
    int seen, w, s;
    w = int'(dev_width);
    e.is_err = bad; e.is_read = !wr; e.is_write = wr;
    e.beats  = bad ? 0 : ((sz > w) ? (1 << (sz - w)) : 1);
    e.rdata  = (wr || bad) ? 32'd0 : model_read(a, sz);
    exp_q.push_back(e);
    if (wr && !bad) begin
      s = 1 << sz;
      for (int i = 0; i < s; i++) exp_mem[(a + i) & 63] = wd[(big_b ? (s - 1 - i) : i)*8 +: 8];
    end
    @(negedge clk);
    cur_addr = a;
    cur_step = 1 << ((sz < w) ? sz : w);
    cur_base = dev_total;
    seen = mon_hs;
    req_valid = 1; req_write = wr; req_size = 2'(sz);
    req_addr = 32'(a); req_wdata = wd;
    while (mon_hs == seen) @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_reset(input bit pin);
    rst_n = 0;
    mode_pin = pin;
    big_b = !pin;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mode_pin = !pin; // R1: pin changes after reset must be ignored
    #2;
    main_checks++;
    if (req_ready !== 1'b0 || ext_valid !== 1'b0) begin
      main_errors++;
      $display("FAIL R6 reset state: actual=%b%b expected=00", req_ready, ext_valid);
    end
  endtask

  function automatic bit width_legal(input int mk, input int w);
    case (mk)
      0: return w <= 2;
      1: return w == 1 || w == 2;
      2: return w <= 1;
      default: return 0;
    endcase
  endfunction

  task automatic finish_run(input int extra);
    $display("  Result: errors=%0d of %0d checks",
             mon_errors + main_errors + extra, mon_checks + main_checks + extra);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run(1);
  end

  initial begin
    int seed;
    seed = 0;
    for (int j = 0; j < 64; j++) begin
      mem[j] = 8'(j * 7 + 3);
      exp_mem[j] = mem[j];
    end
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int mk = 0; mk < 4; mk++) begin
        for (int w = 0; w < 3; w++) begin
          mem_kind = 2'(mk);
          dev_width = 2'(w);
          if (!width_legal(mk, w)) begin
            access(0, 2, 0, 0, 1); // R7
          end else begin
            for (int sz = 0; sz < 3; sz++) begin
              for (int k = 0; k < 2; k++) begin
                int a;
                a = 16 + k * 20 + ((sz == 0) ? 3 : ((sz == 1) ? 6 : 0));
                seed++;
                access(0, sz, a, 0, 0);
                access(1, sz, a, 32'h1234_5678 + 32'(seed) * 32'h0F1E_2D3B, 0);
                access(0, sz, a, 0, 0);
              end
            end
            access(0, 1, 17, 0, 1);             // R8 odd word
            access(1, 2, 18, 32'hFFFF_FFFF, 1); // R8 long on half boundary
            access(0, 3, 20, 0, 1);             // R8 reserved size
          end
        end
      end
    end
    repeat (4) @(negedge clk);
    finish_run(0);
  end
endmodule